// File: doc/BRIEF.md
# Shared Memory Slot Arbiter

This block decides, once per memory cycle, which requester owns a single shared memory bus. Memory cycles alternate between two kinds of slot. Odd slots belong to fixed custom DMA, which is outside this block, so no requester handled here is granted in an odd slot. In even slots three requesters compete: the processor, the block-copy engine (blitter) and the display bitplane fetch engine.

The display fetch takes even slots only in deep colour modes and only while its fetch window is open. When that happens it ranks above everything else. Below it, the blitter either takes every even slot it asks for (priority mode), or it steps aside for one slot after the processor has been refused three even slots in a row. A starvation counter reports how many consecutive slots the processor has been refused.

Decisions are registered. The grant outputs and `slot_odd` that are visible during a cycle describe the slot decided at the previous rising edge. Reset restarts the slot sequence on an even slot.

Top module: `dsa_slot_arbiter`

## Requirements
- R1: After reset the first decided slot is even (`slot_odd`=0), `slot_odd` then toggles every cycle, and no grant is ever asserted with `slot_odd`=1.
- R2: With no blitter request and no deep display fetch, a requesting processor is granted every even slot, so it never waits.
- R3: With `blt_pri`=1 and `blt_req`=1, the blitter is granted every even slot the display fetch does not claim, and the processor receives no grant.
- R4: With `blt_pri`=0 and both processor and blitter requesting, the processor is granted the even slot that follows three consecutive refused even slots. Under a steady load this gives one processor grant in every four even slots, and the blitter gets the other three.
- R5: With `fetch_win`=1, the display fetch claims every even slot when `hires`=0 and `plane_cnt`>=5, or when `hires`=1 and `plane_cnt`>=3. A claimed slot goes to the display fetch ahead of both the blitter and the processor.
- R6: With fewer planes than the mode threshold, or with `fetch_win`=0, the display fetch is never granted.
- R7: `starve_cnt` rises by one on each even slot in which the processor requests and is refused, and it saturates at its maximum. It returns to zero on a processor grant or on any cycle in which `cpu_req` is low.
- R8: At most one grant is asserted per cycle, and a requester that was not requesting when the slot was decided is never granted.
- R9: Synchronous active-high reset deasserts all grants, zeroes `starve_cnt` and makes the next decided slot even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor requests the bus |
| blt_req | input | 1 | Blitter requests the bus |
| blt_pri | input | 1 | 1: blitter takes every slot it wants; 0: blitter yields after processor starvation |
| plane_cnt | input | 3 | Number of enabled bitplanes |
| hires | input | 1 | High-resolution display mode |
| fetch_win | input | 1 | Display fetch window is open |
| gnt_cpu | output | 1 | Processor owns the slot just decided |
| gnt_blt | output | 1 | Blitter owns the slot just decided |
| gnt_bpl | output | 1 | Display fetch owns the slot just decided |
| slot_odd | output | 1 | Parity of the slot just decided (1 = odd, custom DMA) |
| starve_cnt | output | 6 | Consecutive refused processor slots |

## Verification
The bench covers the four load cases on grant rate, and it counts processor, blitter and display grants over sixteen even slots. A design with an off-by-one yield threshold would give one processor grant in three or five slots instead of one in four. A design that counts odd slots toward starvation would let the processor in twice as often. Both threshold edges are tested in each resolution: four versus five planes in low resolution, and two versus three in high resolution. A wrong comparison there would either leave the processor starving or let the display lose slots. The tests also include a blitter that requests with no competing processor, which must keep every slot, and a processor request that drops partway through a starvation run, which must clear the counter at once.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_BLT  = 2'd2,
      OWN_BPL  = 2'd3
   } owner_e;

   typedef struct packed {
      logic bpl;
      logic blt;
      logic cpu;
   } grant_t;

   function automatic grant_t owner_to_grant(owner_e o);
      grant_t g;
      g.cpu = (o == OWN_CPU);
      g.blt = (o == OWN_BLT);
      g.bpl = (o == OWN_BPL);
      return g;
   endfunction
endpackage

// File: rtl/dsa_parity.sv
module dsa_parity (
   input  logic clk,
   input  logic rst,
   output logic odd_now
);
   logic odd_q;

   always_ff @(posedge clk) begin
      if (rst) odd_q <= 1'b0;
      else     odd_q <= ~odd_q;
   end

   assign odd_now = odd_q;
endmodule

// File: rtl/dsa_depth.sv
module dsa_depth #(
   parameter int PLANE_W    = 3,
   parameter int LORES_DEEP = 5,
   parameter int HIRES_DEEP = 3,
   parameter bit FETCH_EN   = 1'b1
) (
   input  logic [PLANE_W-1:0] plane_cnt,
   input  logic               hires,
   input  logic               fetch_win,
   output logic               claim
);
   localparam int PLANE_MAX = (1 << PLANE_W) - 1;

   if (LORES_DEEP < 1 || LORES_DEEP > PLANE_MAX) begin : g_bad_lores
      $error("LORES_DEEP outside plane count range");
   end
   if (HIRES_DEEP < 1 || HIRES_DEEP > PLANE_MAX) begin : g_bad_hires
      $error("HIRES_DEEP outside plane count range");
   end

   localparam logic [PLANE_W-1:0] LO_TH = PLANE_W'(LORES_DEEP);
   localparam logic [PLANE_W-1:0] HI_TH = PLANE_W'(HIRES_DEEP);

   if (FETCH_EN) begin : g_fetch
      logic deep;
      always_comb begin
         if (hires) deep = (plane_cnt >= HI_TH);
         else       deep = (plane_cnt >= LO_TH);
      end
      assign claim = fetch_win & deep;
   end else begin : g_nofetch
      logic unused_in;
      assign unused_in = ^{plane_cnt, hires, fetch_win};
      assign claim     = 1'b0;
   end
endmodule

// File: rtl/dsa_starve.sv
module dsa_starve #(
   parameter int STARVE_W    = 6,
   parameter int YIELD_AFTER = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                even_slot,
   input  logic                cpu_req,
   input  logic                cpu_won,
   output logic [STARVE_W-1:0] cnt,
   output logic                yield
);
   localparam int CNT_MAX = (1 << STARVE_W) - 1;

   if (YIELD_AFTER < 1 || YIELD_AFTER > CNT_MAX) begin : g_bad_yield
      $error("YIELD_AFTER must fit in the starvation counter");
   end

   localparam logic [STARVE_W-1:0] MAXV = STARVE_W'(CNT_MAX);
   localparam logic [STARVE_W-1:0] YTH  = STARVE_W'(YIELD_AFTER);

   logic [STARVE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                     cnt_q <= '0;
      else if (!cpu_req)           cnt_q <= '0;
      else if (even_slot) begin
         if (cpu_won)              cnt_q <= '0;
         else if (cnt_q != MAXV)   cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt   = cnt_q;
   assign yield = (cnt_q >= YTH);
endmodule

// File: rtl/dsa_pick.sv
module dsa_pick
   import dsa_pkg::*;
(
   input  logic   odd_slot,
   input  logic   bpl_claim,
   input  logic   blt_req,
   input  logic   blt_pri,
   input  logic   cpu_req,
   input  logic   cpu_yield,
   output owner_e owner
);
   always_comb begin
      owner = OWN_NONE;
      if (!odd_slot) begin
         if (bpl_claim)                         owner = OWN_BPL;
         else if (blt_req && (blt_pri || !(cpu_req && cpu_yield)))
                                                owner = OWN_BLT;
         else if (cpu_req)                      owner = OWN_CPU;
      end
   end
endmodule

// File: rtl/dsa_slot_arbiter.sv
module dsa_slot_arbiter
   import dsa_pkg::*;
#(
   parameter int PLANE_W     = 3,
   parameter int LORES_DEEP  = 5,
   parameter int HIRES_DEEP  = 3,
   parameter int STARVE_W    = 6,
   parameter int YIELD_AFTER = 3,
   parameter bit FETCH_EN    = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cpu_req,
   input  logic                blt_req,
   input  logic                blt_pri,
   input  logic [PLANE_W-1:0]  plane_cnt,
   input  logic                hires,
   input  logic                fetch_win,
   output logic                gnt_cpu,
   output logic                gnt_blt,
   output logic                gnt_bpl,
   output logic                slot_odd,
   output logic [STARVE_W-1:0] starve_cnt
);
   logic   odd_now;
   logic   claim;
   logic   yield;
   owner_e owner;
   grant_t gnt_d, gnt_q;
   logic   odd_q;

   dsa_parity u_parity (
      .clk     (clk),
      .rst     (rst),
      .odd_now (odd_now)
   );

   dsa_depth #(
      .PLANE_W    (PLANE_W),
      .LORES_DEEP (LORES_DEEP),
      .HIRES_DEEP (HIRES_DEEP),
      .FETCH_EN   (FETCH_EN)
   ) u_depth (
      .plane_cnt (plane_cnt),
      .hires     (hires),
      .fetch_win (fetch_win),
      .claim     (claim)
   );

   dsa_pick u_pick (
      .odd_slot  (odd_now),
      .bpl_claim (claim),
      .blt_req   (blt_req),
      .blt_pri   (blt_pri),
      .cpu_req   (cpu_req),
      .cpu_yield (yield),
      .owner     (owner)
   );

   assign gnt_d = owner_to_grant(owner);

   dsa_starve #(
      .STARVE_W    (STARVE_W),
      .YIELD_AFTER (YIELD_AFTER)
   ) u_starve (
      .clk       (clk),
      .rst       (rst),
      .even_slot (~odd_now),
      .cpu_req   (cpu_req),
      .cpu_won   (gnt_d.cpu),
      .cnt       (starve_cnt),
      .yield     (yield)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt_q <= '0;
         odd_q <= 1'b1;
      end else begin
         gnt_q <= gnt_d;
         odd_q <= odd_now;
      end
   end

   assign gnt_cpu  = gnt_q.cpu;
   assign gnt_blt  = gnt_q.blt;
   assign gnt_bpl  = gnt_q.bpl;
   assign slot_odd = odd_q;
endmodule

// File: rtl/dsa_slot_arbiter_chk.sv
module dsa_slot_arbiter_chk #(
   parameter int STARVE_W = 6
) (
   input logic                clk,
   input logic                rst,
   input logic                cpu_req,
   input logic                blt_req,
   input logic                blt_pri,
   input logic                gnt_cpu,
   input logic                gnt_blt,
   input logic                gnt_bpl,
   input logic                slot_odd,
   input logic [STARVE_W-1:0] starve_cnt
);
   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({gnt_cpu, gnt_blt, gnt_bpl}));                              // R8
   AST_ODD_NO_GNT: assert property (@(posedge clk) disable iff (rst)
      slot_odd |-> !(gnt_cpu || gnt_blt || gnt_bpl));                      // R1
   AST_CPU_REQUESTED: assert property (@(posedge clk) disable iff (rst)
      $rose(gnt_cpu) |-> $past(cpu_req));                                  // R8
   AST_BLT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
      $rose(gnt_blt) |-> $past(blt_req));                                  // R8
   AST_PRI_LOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
      $rose(gnt_cpu) |-> !($past(blt_req) && $past(blt_pri)));             // R3
   AST_CPU_CLEARS_STARVE: assert property (@(posedge clk) disable iff (rst)
      gnt_cpu |-> (starve_cnt == '0));                                     // R7
   AST_PARITY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      !$stable(slot_odd) || $past(rst));                                   // R1
endmodule

bind dsa_slot_arbiter dsa_slot_arbiter_chk #(.STARVE_W(STARVE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cpu_req    (cpu_req),
   .blt_req    (blt_req),
   .blt_pri    (blt_pri),
   .gnt_cpu    (gnt_cpu),
   .gnt_blt    (gnt_blt),
   .gnt_bpl    (gnt_bpl),
   .slot_odd   (slot_odd),
   .starve_cnt (starve_cnt)
);

// File: tb/dsa_slot_arbiter_tb.sv
module dsa_slot_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cpu_req = 1'b0, blt_req = 1'b0, blt_pri = 1'b0;
   logic [2:0] plane_cnt = 3'd0;
   logic       hires = 1'b0, fetch_win = 1'b0;
   logic       gnt_cpu, gnt_blt, gnt_bpl, slot_odd;
   logic [5:0] starve_cnt;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   dsa_slot_arbiter dut_i (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .blt_req(blt_req),
      .blt_pri(blt_pri), .plane_cnt(plane_cnt), .hires(hires),
      .fetch_win(fetch_win), .gnt_cpu(gnt_cpu), .gnt_blt(gnt_blt),
      .gnt_bpl(gnt_bpl), .slot_odd(slot_odd), .starve_cnt(starve_cnt)
   );

   typedef struct packed {
      logic       cpu;
      logic       blt;
      logic       pri;
      logic [2:0] planes;
      logic       hi;
      logic       win;
      logic [5:0] e_cpu;
      logic [5:0] e_blt;
      logic [5:0] e_bpl;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 6'd16, 6'd0,  6'd0 },  // R2 idle blitter
      '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 6'd4,  6'd12, 6'd0 },  // R4 one in four
      '{1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 6'd0,  6'd16, 6'd0 },  // R3 priority
      '{1'b1, 1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 6'd0,  6'd0,  6'd16},  // R5 lores 5
      '{1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 6'd16, 6'd0,  6'd0 },  // R6 lores 4
      '{1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 6'd0,  6'd0,  6'd16},  // R5 hires 3
      '{1'b1, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 6'd16, 6'd0,  6'd0 },  // R6 hires 2
      '{1'b1, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, 6'd4,  6'd12, 6'd0 },  // R6 window shut
      '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 6'd0,  6'd0,  6'd0 },  // R8 no requests
      '{1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 6'd0,  6'd16, 6'd0 },  // R4 lone blitter
      '{1'b1, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 6'd0,  6'd0,  6'd16}   // R5 above blitter
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #400000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      // R9 reset state
      cpu_req = 1'b1; blt_req = 1'b1;
      @(negedge clk); @(negedge clk);
      check({gnt_cpu, gnt_blt, gnt_bpl} == 3'b000, "R9 grants", {gnt_cpu, gnt_blt, gnt_bpl}, 0);
      check(starve_cnt == 6'd0, "R9 starve", starve_cnt, 0);

      for (int v = 0; v < NV; v++) begin
         int c_cpu, c_blt, c_bpl, odd_bad, par_bad, multi;
         c_cpu = 0; c_blt = 0; c_bpl = 0; odd_bad = 0; par_bad = 0; multi = 0;
         @(negedge clk);
         rst = 1'b1;
         cpu_req = VECS[v].cpu; blt_req = VECS[v].blt; blt_pri = VECS[v].pri;
         plane_cnt = VECS[v].planes; hires = VECS[v].hi; fetch_win = VECS[v].win;
         @(negedge clk);
         rst = 1'b0;
         for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (slot_odd != 1'(i % 2)) par_bad++;
            if (slot_odd && (gnt_cpu || gnt_blt || gnt_bpl)) odd_bad++;
            if (32'(gnt_cpu) + 32'(gnt_blt) + 32'(gnt_bpl) > 1) multi++;
            c_cpu += int'(gnt_cpu); c_blt += int'(gnt_blt); c_bpl += int'(gnt_bpl);
         end
         check(c_cpu == int'(VECS[v].e_cpu), $sformatf("R2/R3/R4 cpu grants v%0d", v), c_cpu, VECS[v].e_cpu);
         check(c_blt == int'(VECS[v].e_blt), $sformatf("R3/R4 blt grants v%0d", v), c_blt, VECS[v].e_blt);
         check(c_bpl == int'(VECS[v].e_bpl), $sformatf("R5/R6 bpl grants v%0d", v), c_bpl, VECS[v].e_bpl);
         check(par_bad == 0, "R1 parity", par_bad, 0);
         check(odd_bad == 0, "R1 odd slot grant", odd_bad, 0);
         check(multi == 0, "R8 one-hot", multi, 0);
      end

      // R7 starvation count sequence and clear on grant
      @(negedge clk);
      rst = 1'b1; cpu_req = 1'b1; blt_req = 1'b1; blt_pri = 1'b0;
      plane_cnt = 3'd0; fetch_win = 1'b0; hires = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk); check(starve_cnt == 6'd1, "R7 count after slot0", starve_cnt, 1);
      @(negedge clk); check(starve_cnt == 6'd1, "R7 hold on odd", starve_cnt, 1);
      @(negedge clk); check(starve_cnt == 6'd2, "R7 count after slot2", starve_cnt, 2);
      @(negedge clk);
      @(negedge clk); check(starve_cnt == 6'd3, "R7 count after slot4", starve_cnt, 3);
      @(negedge clk);
      @(negedge clk);
      check(gnt_cpu == 1'b1, "R4 yield grant", gnt_cpu, 1);
      check(starve_cnt == 6'd0, "R7 clear on grant", starve_cnt, 0);

      // R7 request drop clears counter
      do_reset();
      @(negedge clk); @(negedge clk); @(negedge clk);
      check(starve_cnt == 6'd2, "R7 pre-drop", starve_cnt, 2);
      cpu_req = 1'b0;
      @(negedge clk);
      check(starve_cnt == 6'd0, "R7 drop clears", starve_cnt, 0);

      // R7 saturation under priority blitter
      blt_pri = 1'b1; cpu_req = 1'b1;
      do_reset();
      for (int i = 0; i < 140; i++) @(negedge clk);
      check(starve_cnt == 6'd63, "R7 saturate", starve_cnt, 63);
      check(gnt_cpu == 1'b0, "R3 still locked", gnt_cpu, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule